// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block gives a host two small ports through which it reaches the configuration registers of devices behind it. The host first writes a 32-bit selector through the selector port. The selector carries an enable flag, a bus number, a device/function number and a register offset. Later accesses through the data port become configuration transactions. The block sends each one on a downstream request channel and returns the result to the host.

The data-port byte offset is ORed into the low bits of the selector. Byte and halfword accesses inside the addressed dword therefore reach the correct register byte. The access length is clamped so that a transaction never runs past the end of the 256-byte configuration space. When the selector is disabled, or when the downstream side reports that no device answers, a read returns all ones and a write has no visible result. While a transaction is in flight the block holds the host off with a busy flag.

A parameter chooses how bytes are placed between the host data bus and the downstream data. In the default order the lanes pass straight through. The other order reverses the four bytes of both the write data and the read data.

Top module: `cfg_indirect_bridge`

## Requirements
- R1: After a synchronous reset the selector reads as 0, and host_busy, dn_valid and host_rvalid are all low.
- R2: The selector changes only on a selector-port write (host_port=0) with host_off=0 and size code 3 (4 bytes). Any other offset or size code leaves it unchanged. Size codes 0..3 stand for 1..4 bytes.
- R3: A selector-port read, at any offset and size, raises host_rvalid for one cycle in the cycle after the request, with host_rdata equal to the full 32-bit selector.
- R4: While selector bit 31 is 0, a data-port read (host_port=1) returns 0xFFFFFFFF with host_rvalid in the next cycle. A data-port write in that state issues no downstream request and leaves host_busy low.
- R5: While selector bit 31 is 1, a data-port access raises dn_valid in the next cycle. The effective address is the selector ORed with host_off. dn_bus takes bits 23:16, dn_devfn takes bits 15:8 and dn_reg takes bits 7:0. dn_wr and dn_wdata follow the request. All of these hold steady until dn_ready is seen high.
- R6: dn_len equals the smaller of (size code + 1) and (256 - dn_reg).
- R7: When dn_rsp_valid arrives for a read with dn_rsp_present=1, host_rvalid rises in the next cycle with host_rdata equal to dn_rsp_rdata (default lane order).
- R8: When the response of a read has dn_rsp_present=0, host_rdata is 0xFFFFFFFF. The completion of a write, present or not, raises no host_rvalid.
- R9: host_busy is high from the cycle after an enabled data-port access until the cycle after its response. Host requests made while busy are ignored, including selector writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Single-cycle host request strobe |
| host_port | input | 1 | 0 = selector port, 1 = data port |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 2 | Byte offset within the port |
| host_size | input | 2 | Size code, bytes minus one |
| host_wdata | input | 32 | Host write data |
| host_busy | output | 1 | Data transaction in flight; host must wait |
| host_rvalid | output | 1 | One-cycle read data valid |
| host_rdata | output | 32 | Read data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_wr | output | 1 | Downstream write flag |
| dn_bus | output | 8 | Bus number |
| dn_devfn | output | 8 | Device/function number |
| dn_reg | output | 8 | Register byte offset |
| dn_len | output | 3 | Access length in bytes, 1..4 |
| dn_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_present | input | 1 | A device answered at the address |
| dn_rsp_rdata | input | 32 | Downstream read data |

## Verification
The properties assume that the downstream side gives one single-cycle response only after a request has been accepted, and never in the same cycle as dn_ready. Under that assumption, the cycles in which host_busy is high with dn_valid low mark the wait for a response. The properties that tie a host request to its result are gated on host_busy being low, because a request made while busy is ignored. The bench's downstream model is sequential: it raises dn_ready after a random stall, then drives exactly one response pulse after a further random delay. It also issues one deliberate selector write while the block is busy, to show that the write is dropped.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int unsigned HOST_DW    = 32;
  localparam int unsigned HOST_BYTES = HOST_DW / 8;
  localparam int unsigned LANE_W     = $clog2(HOST_BYTES);
  localparam int unsigned LEN_W      = $clog2(HOST_BYTES + 1);
  localparam int unsigned CFG_SPACE  = 256;
  localparam int unsigned REG_W      = $clog2(CFG_SPACE);
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned DEVFN_LSB  = REG_W;
  localparam int unsigned BUS_LSB    = DEVFN_LSB + FIELD_W;
  localparam int unsigned ADDR_TOP   = BUS_LSB + FIELD_W;
  localparam int unsigned EN_BIT     = HOST_DW - 1;

  localparam logic PORT_SEL  = 1'b0;
  localparam logic PORT_DATA = 1'b1;
  localparam logic [LANE_W-1:0] SIZE_FULL = LANE_W'(HOST_BYTES - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } bridge_state_e;
endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/cfg_addr_comp.sv
module cfg_addr_comp
  import cfg_bridge_pkg::*;
(
  input  logic [ADDR_TOP-1:0] sel_addr,
  input  logic [LANE_W-1:0]   off,
  input  logic [LANE_W-1:0]   size,
  output logic [FIELD_W-1:0]  bus,
  output logic [FIELD_W-1:0]  devfn,
  output logic [REG_W-1:0]    reg_off,
  output logic [LEN_W-1:0]    len
);
  localparam int unsigned AV_W = REG_W + 1;

  logic [ADDR_TOP-1:0] eff;
  logic [AV_W-1:0]     avail;
  logic [LEN_W-1:0]    want;

  always_comb begin
    eff     = sel_addr | ADDR_TOP'(off);
    bus     = eff[BUS_LSB +: FIELD_W];
    devfn   = eff[DEVFN_LSB +: FIELD_W];
    reg_off = eff[REG_W-1:0];
    avail   = AV_W'(CFG_SPACE) - AV_W'(reg_off);
    want    = LEN_W'(size) + LEN_W'(1);
    len     = (AV_W'(want) <= avail) ? want : avail[LEN_W-1:0];
  end
endmodule

// File: rtl/cfg_lane_map.sv
module cfg_lane_map #(
  parameter int unsigned BYTES = 4,
  parameter bit          SWAP  = 1'b0
) (
  input  logic [BYTES*8-1:0] din,
  output logic [BYTES*8-1:0] dout
);
  generate
    if (SWAP) begin : g_swap
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/cfg_indirect_bridge.sv
module cfg_indirect_bridge
  import cfg_bridge_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_req,
  input  logic                 host_port,
  input  logic                 host_wr,
  input  logic [LANE_W-1:0]    host_off,
  input  logic [LANE_W-1:0]    host_size,
  input  logic [HOST_DW-1:0]   host_wdata,
  output logic                 host_busy,
  output logic                 host_rvalid,
  output logic [HOST_DW-1:0]   host_rdata,
  output logic                 dn_valid,
  input  logic                 dn_ready,
  output logic                 dn_wr,
  output logic [FIELD_W-1:0]   dn_bus,
  output logic [FIELD_W-1:0]   dn_devfn,
  output logic [REG_W-1:0]     dn_reg,
  output logic [LEN_W-1:0]     dn_len,
  output logic [HOST_DW-1:0]   dn_wdata,
  input  logic                 dn_rsp_valid,
  input  logic                 dn_rsp_present,
  input  logic [HOST_DW-1:0]   dn_rsp_rdata
);
  bridge_state_e        state;
  logic [HOST_DW-1:0]   sel_q;
  logic                 accept;
  logic                 sel_we;
  logic [FIELD_W-1:0]   c_bus;
  logic [FIELD_W-1:0]   c_devfn;
  logic [REG_W-1:0]     c_reg;
  logic [LEN_W-1:0]     c_len;
  logic [HOST_DW-1:0]   wdata_lane;
  logic [HOST_DW-1:0]   rdata_lane;

  assign accept = host_req && (state == ST_IDLE);
  assign sel_we = accept && (host_port == PORT_SEL) && host_wr &&
                  (host_off == '0) && (host_size == SIZE_FULL);
  assign host_busy = (state != ST_IDLE);

  cfg_sel_reg #(.W(HOST_DW)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .we    (sel_we),
    .wdata (host_wdata),
    .q     (sel_q)
  );

  cfg_addr_comp u_addr (
    .sel_addr (sel_q[ADDR_TOP-1:0]),
    .off      (host_off),
    .size     (host_size),
    .bus      (c_bus),
    .devfn    (c_devfn),
    .reg_off  (c_reg),
    .len      (c_len)
  );

  cfg_lane_map #(.BYTES(HOST_BYTES), .SWAP(BIG_ENDIAN)) u_wlane (
    .din  (host_wdata),
    .dout (wdata_lane)
  );

  cfg_lane_map #(.BYTES(HOST_BYTES), .SWAP(BIG_ENDIAN)) u_rlane (
    .din  (dn_rsp_rdata),
    .dout (rdata_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      dn_valid    <= 1'b0;
      dn_wr       <= 1'b0;
      dn_bus      <= '0;
      dn_devfn    <= '0;
      dn_reg      <= '0;
      dn_len      <= '0;
      dn_wdata    <= '0;
    end else begin
      host_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (host_port == PORT_SEL) begin
              if (!host_wr) begin
                host_rvalid <= 1'b1;
                host_rdata  <= sel_q;
              end
            end else if (!sel_q[EN_BIT]) begin
              if (!host_wr) begin
                host_rvalid <= 1'b1;
                host_rdata  <= '1;
              end
            end else begin
              state    <= ST_REQ;
              dn_valid <= 1'b1;
              dn_wr    <= host_wr;
              dn_bus   <= c_bus;
              dn_devfn <= c_devfn;
              dn_reg   <= c_reg;
              dn_len   <= c_len;
              dn_wdata <= wdata_lane;
            end
          end
        end
        ST_REQ: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            state <= ST_IDLE;
            if (!dn_wr) begin
              host_rvalid <= 1'b1;
              host_rdata  <= dn_rsp_present ? rdata_lane : '1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_indirect_bridge_chk.sv
module cfg_indirect_bridge_chk
  import cfg_bridge_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 host_req,
  input logic                 host_port,
  input logic                 host_wr,
  input logic [LANE_W-1:0]    host_off,
  input logic [LANE_W-1:0]    host_size,
  input logic [HOST_DW-1:0]   host_wdata,
  input logic                 host_busy,
  input logic                 host_rvalid,
  input logic [HOST_DW-1:0]   host_rdata,
  input logic                 dn_valid,
  input logic                 dn_ready,
  input logic                 dn_wr,
  input logic [FIELD_W-1:0]   dn_bus,
  input logic [FIELD_W-1:0]   dn_devfn,
  input logic [REG_W-1:0]     dn_reg,
  input logic [LEN_W-1:0]     dn_len,
  input logic [HOST_DW-1:0]   dn_wdata,
  input logic                 dn_rsp_valid,
  input logic                 dn_rsp_present,
  input logic [HOST_DW-1:0]   sel
);
  logic idle_req;
  assign idle_req = host_req && !host_busy;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!host_busy && !dn_valid && !host_rvalid && sel == '0));

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_req && host_port == PORT_SEL && host_wr && host_off == '0 && host_size == SIZE_FULL)
    |=> sel == $past(host_wdata));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_req && host_port == PORT_SEL && host_wr && (host_off != '0 || host_size != SIZE_FULL))
    |=> $stable(sel));

  // R3
  sel_read_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_req && host_port == PORT_SEL && !host_wr) |=> (host_rvalid && host_rdata == sel));

  // R4
  off_read_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_req && host_port == PORT_DATA && !host_wr && !sel[EN_BIT])
    |=> (host_rvalid && host_rdata == '1));

  // R4
  off_write_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_req && host_port == PORT_DATA && host_wr && !sel[EN_BIT])
    |=> (!dn_valid && !host_busy));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready)
    |=> (dn_valid && $stable({dn_wr, dn_bus, dn_devfn, dn_reg, dn_len, dn_wdata})));

  // R5
  req_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (sel[EN_BIT] && host_busy));

  // R6
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_len != '0 && dn_len <= LEN_W'(HOST_BYTES) &&
                  ({1'b0, dn_reg} + (REG_W+1)'(dn_len)) <= (REG_W+1)'(CFG_SPACE)));

  // R8
  absent_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rsp_valid && host_busy && !dn_valid && !dn_wr && !dn_rsp_present)
    |=> (host_rvalid && host_rdata == '1));

  // R8
  write_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rsp_valid && host_busy && !dn_valid && dn_wr) |=> (!host_rvalid && !host_busy));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rsp_valid && host_busy && !dn_valid) |=> !host_busy);
endmodule

bind cfg_indirect_bridge cfg_indirect_bridge_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .host_req       (host_req),
  .host_port      (host_port),
  .host_wr        (host_wr),
  .host_off       (host_off),
  .host_size      (host_size),
  .host_wdata     (host_wdata),
  .host_busy      (host_busy),
  .host_rvalid    (host_rvalid),
  .host_rdata     (host_rdata),
  .dn_valid       (dn_valid),
  .dn_ready       (dn_ready),
  .dn_wr          (dn_wr),
  .dn_bus         (dn_bus),
  .dn_devfn       (dn_devfn),
  .dn_reg         (dn_reg),
  .dn_len         (dn_len),
  .dn_wdata       (dn_wdata),
  .dn_rsp_valid   (dn_rsp_valid),
  .dn_rsp_present (dn_rsp_present),
  .sel            (sel_q)
);

// File: tb/cfg_indirect_bridge_tb.sv
module cfg_indirect_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int N_RANDOM   = 400;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_req, host_port, host_wr;
  logic [1:0]  host_off, host_size;
  logic [31:0] host_wdata;
  logic        host_busy, host_rvalid;
  logic [31:0] host_rdata;
  logic        dn_valid, dn_ready, dn_wr;
  logic [7:0]  dn_bus, dn_devfn, dn_reg;
  logic [2:0]  dn_len;
  logic [31:0] dn_wdata;
  logic        dn_rsp_valid, dn_rsp_present;
  logic [31:0] dn_rsp_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] model_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_indirect_bridge u_dut (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_port(host_port), .host_wr(host_wr),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_wr(dn_wr),
    .dn_bus(dn_bus), .dn_devfn(dn_devfn), .dn_reg(dn_reg), .dn_len(dn_len),
    .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_present(dn_rsp_present), .dn_rsp_rdata(dn_rsp_rdata)
  );

  function automatic logic [2:0] exp_len(input logic [7:0] r, input logic [1:0] sz);
    int want = int'(sz) + 1;
    int room = 256 - int'(r);
    return 3'((want < room) ? want : room);
  endfunction

  function automatic bit dev_here(input logic [7:0] b, input logic [7:0] df);
    return (b < 8'd4) && (df[2:0] != 3'd7);
  endfunction

  function automatic logic [31:0] rsp_word(input logic [7:0] b, input logic [7:0] df,
                                           input logic [7:0] r);
    return {b ^ 8'h5A, df, r, ~r};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_issue(input logic port, input logic wr, input logic [1:0] off,
                            input logic [1:0] sz, input logic [31:0] wd);
    host_req = 1'b1; host_port = port; host_wr = wr;
    host_off = off; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic sel_write(input logic [1:0] off, input logic [1:0] sz, input logic [31:0] v);
    host_issue(1'b0, 1'b1, off, sz, v);
    if (off == 2'd0 && sz == 2'd3) model_sel = v;
    chk(!host_rvalid && !host_busy, "R2 write quiet", {30'b0, host_rvalid, host_busy}, 32'h0);
  endtask

  task automatic sel_read(input logic [1:0] off, input logic [1:0] sz, input string tag);
    host_issue(1'b0, 1'b0, off, sz, 32'h0);
    chk(host_rvalid == 1'b1, tag, {31'b0, host_rvalid}, 32'h1);
    chk(host_rdata == model_sel, tag, host_rdata, model_sel);
  endtask

  task automatic data_access(input logic wr, input logic [1:0] off, input logic [1:0] sz,
                             input logic [31:0] wd, input int rdy_dly, input int rsp_dly,
                             input bit poke_sel);
    logic [31:0] eff;
    logic [7:0]  eb, ed, er;
    logic [2:0]  el;
    bit          pres;
    logic [31:0] word;
    host_issue(1'b1, wr, off, sz, wd);
    if (!model_sel[31]) begin
      if (wr) begin
        chk(!dn_valid && !host_busy, "R4 write dropped",
            {30'b0, dn_valid, host_busy}, 32'h0);
      end else begin
        chk(host_rvalid && host_rdata == 32'hFFFF_FFFF, "R4 read ones",
            host_rdata, 32'hFFFF_FFFF);
      end
      return;
    end
    eff  = model_sel | {30'b0, off};
    eb   = eff[23:16]; ed = eff[15:8]; er = eff[7:0];
    el   = exp_len(er, sz);
    pres = dev_here(eb, ed);
    word = rsp_word(eb, ed, er);
    chk(dn_valid && host_busy, "R9 busy/valid", {30'b0, dn_valid, host_busy}, 32'h3);
    chk(dn_bus == eb && dn_devfn == ed && dn_reg == er, "R5 address",
        {8'h0, dn_bus, dn_devfn, dn_reg}, {8'h0, eb, ed, er});
    chk(dn_len == el, "R6 length", {29'b0, dn_len}, {29'b0, el});
    chk(dn_wr == wr, "R5 direction", {31'b0, dn_wr}, {31'b0, wr});
    if (wr) chk(dn_wdata == wd, "R5 wdata", dn_wdata, wd);
    for (int i = 0; i < rdy_dly; i++) begin
      if (poke_sel && i == 0) begin
        host_req = 1'b1; host_port = 1'b0; host_wr = 1'b1;
        host_off = 2'd0; host_size = 2'd3; host_wdata = 32'h0;
      end
      @(negedge clk);
      host_req = 1'b0;
      chk(dn_valid && dn_reg == er && dn_len == el, "R5 hold",
          {23'b0, dn_valid, dn_reg}, {23'b0, 1'b1, er});
    end
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk(!dn_valid && host_busy, "R9 waiting", {30'b0, dn_valid, host_busy}, 32'h1);
    for (int i = 0; i < rsp_dly; i++) @(negedge clk);
    dn_rsp_valid = 1'b1; dn_rsp_present = pres; dn_rsp_rdata = word;
    @(negedge clk);
    dn_rsp_valid = 1'b0; dn_rsp_present = 1'b0; dn_rsp_rdata = 32'h0;
    chk(!host_busy, "R9 busy drop", {31'b0, host_busy}, 32'h0);
    if (wr) begin
      chk(!host_rvalid, "R8 write no rvalid", {31'b0, host_rvalid}, 32'h0);
    end else if (pres) begin
      chk(host_rvalid && host_rdata == word, "R7 read data", host_rdata, word);
    end else begin
      chk(host_rvalid && host_rdata == 32'hFFFF_FFFF, "R8 absent read", host_rdata,
          32'hFFFF_FFFF);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; host_req = 1'b0; host_port = 1'b0; host_wr = 1'b0;
    host_off = 2'd0; host_size = 2'd0; host_wdata = 32'h0;
    dn_ready = 1'b0; dn_rsp_valid = 1'b0; dn_rsp_present = 1'b0; dn_rsp_rdata = 32'h0;
    model_sel = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk(!host_busy && !dn_valid && !host_rvalid, "R1 reset outputs",
        {29'b0, host_busy, dn_valid, host_rvalid}, 32'h0);
    sel_read(2'd0, 2'd3, "R1 selector zero");
    data_access(1'b0, 2'd0, 2'd3, 32'h0, 0, 0, 1'b0);
    data_access(1'b1, 2'd0, 2'd3, 32'hDEAD_BEEF, 0, 0, 1'b0);

    sel_write(2'd0, 2'd3, 32'h8001_2344);
    sel_read(2'd2, 2'd0, "R3 read odd offset");
    sel_write(2'd1, 2'd3, 32'h1234_5678);
    sel_read(2'd0, 2'd3, "R2 bad offset ignored");
    sel_write(2'd0, 2'd1, 32'h1234_5678);
    sel_read(2'd3, 2'd1, "R2 bad size ignored");

    data_access(1'b0, 2'd3, 2'd0, 32'h0, 2, 1, 1'b0);
    data_access(1'b1, 2'd2, 2'd1, 32'hCAFE_F00D, 1, 0, 1'b0);
    sel_write(2'd0, 2'd3, 32'h8001_2301);
    data_access(1'b0, 2'd2, 2'd1, 32'h0, 0, 2, 1'b0);

    sel_write(2'd0, 2'd3, 32'h8000_08FC);
    data_access(1'b0, 2'd3, 2'd3, 32'h0, 0, 0, 1'b0);
    data_access(1'b0, 2'd2, 2'd3, 32'h0, 1, 1, 1'b0);
    data_access(1'b1, 2'd1, 2'd2, 32'h0102_0304, 0, 1, 1'b0);

    sel_write(2'd0, 2'd3, 32'h8009_0710);
    data_access(1'b0, 2'd0, 2'd3, 32'h0, 1, 1, 1'b0);
    data_access(1'b1, 2'd0, 2'd3, 32'h5555_AAAA, 0, 0, 1'b0);

    sel_write(2'd0, 2'd3, 32'h8002_1020);
    data_access(1'b0, 2'd0, 2'd3, 32'h0, 3, 0, 1'b1);
    sel_read(2'd0, 2'd3, "R9 selector write while busy ignored");

    for (int n = 0; n < N_RANDOM; n++) begin
      int unsigned op = $urandom % 6;
      logic [1:0]  ro = 2'($urandom);
      logic [1:0]  rs = 2'($urandom);
      logic [31:0] v;
      v = {1'($urandom), 7'($urandom), 8'($urandom % 6), 8'($urandom), 8'($urandom)};
      if ($urandom % 4 == 0) v[7:0] = 8'hFC | 8'($urandom % 4);
      case (op)
        0: sel_write(2'd0, 2'd3, v);
        1: sel_write(ro, rs, v);
        2: sel_read(ro, rs, "R3 random read");
        3, 4: data_access(1'b0, ro, rs, 32'h0, int'($urandom % 4), int'($urandom % 4), 1'b0);
        default: data_access(1'b1, ro, rs, $urandom, int'($urandom % 4),
                             int'($urandom % 4), 1'b0);
      endcase
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule